// File: doc/BRIEF.md
# Prescaled 16-bit timer/counter

This block is a register-mapped up-counter, 16 bits wide, that software reaches through a small byte-wide register port. It counts either a free-running internal tick, one pulse every four system clocks, or rising edges seen on an external digital input. In the external mode the input can pass through a two-flop synchronizer or through a shorter, single-capture path. A prescaler divides the chosen event stream by 1, 2, 4 or 8 before the count advances.

When the count wraps from 0xFFFF to 0x0000 it sets a sticky overflow flag. The interrupt line is raised while that flag and its enable bit are both set. A neighbouring compare unit can clear the count through a dedicated input. The register port has four byte addresses: 0 = control, 1 = count low byte, 2 = count high byte, 3 = interrupt register. Read data is combinational from the address.

Top module: `tmr16_periph`

## Requirements
- R1: After reset every register at addresses 0 to 3 reads 0x00 and irq_o is 0.
- R2: Control register (address 0) layout: bit 0 run, bit 1 source select (0 internal, 1 external), bit 2 external path (0 synchronized, 1 bypassed), bit 3 oscillator-enable flag (stored only), bits 5:4 prescale select. Bits 5:0 read back as written, and bits 7:6 always read 0.
- R3: Each count byte (1 = low, 2 = high) can be written on its own, and the other byte keeps its value. A write to a count byte wins over an increment in the same cycle.
- R4: With the internal source at 1:1 and run set, the count advances by exactly 16 over any 64 clock cycles, which is one step every four clocks.
- R5: With run at 0 the count holds its value, whatever the input activity.
- R6: Prescale select 00, 01, 10, 11 advances the count once per 1, 2, 4, 8 source events.
- R7: In external mode, an input rise sampled at clock edge k shows in the count after edge k+2 when synchronized (bit 2 = 0) and after edge k+1 when bypassed (bit 2 = 1).
- R8: With the internal source selected, bit 2 and the external input have no effect on counting.
- R9: An increment from 0xFFFF gives 0x0000 and sets the overflow flag (address 3, bit 0).
- R10: irq_o is 1 exactly when the overflow flag and the enable bit (address 3, bit 1) are both 1. The flag clears only when 0 is written to bit 0, and writing 1 to it has no effect. If a wrap and a clearing write fall in the same cycle, the flag stays set.
- R11: A one-cycle pulse on cmp_clr_i clears the count to 0x0000. It takes priority over a count write and over an increment in the same cycle.
- R12: Writing either count byte clears the prescaler's partial event count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| ext_clk_i | input | 1 | External event input |
| cmp_clr_i | input | 1 | Count clear request from the compare unit |
| irq_o | output | 1 | Overflow interrupt |

## Verification
Two sets of functions can fall in the same clock edge. The first is a count increment together with a software write: either a write to a count byte, or a write of 0 to the overflow flag landing on the wrap edge. The bench uses the bypassed external path, whose one-edge latency is known, and places the write on exactly the edge where the increment lands. It then judges the result by the written byte surviving, or by the flag staying set. The compare clear is issued in the same cycle as a count write to confirm that the clear wins.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_CNT_LO = 2'd1,
    ADDR_CNT_HI = 2'd2,
    ADDR_IRQ    = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [1:0] rsvd;
    logic [1:0] psc_sel;
    logic       osc_en;
    logic       ext_async;
    logic       src_ext;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/tmr16_clk_src.sv
module tmr16_clk_src #(
  parameter int TICK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic src_ext_i,
  input  logic ext_async_i,
  output logic evt_o
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic tick;

  if (TICK_DIV > 1) begin : g_div
    logic [DIV_W-1:0] div_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) div_q <= '0;
      else if (div_q == DIV_W'(TICK_DIV - 1)) div_q <= '0;
      else div_q <= div_q + 1'b1;
    end
    assign tick = (div_q == DIV_W'(TICK_DIV - 1));
  end else begin : g_nodiv
    assign tick = 1'b1;
  end

  // shr[0] is the capture flop; shr[SYNC_STAGES] is the edge-history flop
  logic [SYNC_STAGES:0] shr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shr_q <= '0;
    else         shr_q <= {shr_q[SYNC_STAGES-1:0], ext_i};
  end

  logic edge_sync, edge_byp;
  assign edge_sync = shr_q[SYNC_STAGES-1] & ~shr_q[SYNC_STAGES];
  assign edge_byp  = shr_q[0] & ~shr_q[1];

  always_comb begin
    if (!src_ext_i)      evt_o = tick;
    else if (ext_async_i) evt_o = edge_byp;
    else                 evt_o = edge_sync;
  end
endmodule

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pulse_o
);
  localparam int PW = (1 << SEL_W) - 1;

  logic [PW-1:0] cnt_q, lim;

  assign lim     = ~({PW{1'b1}} << sel_i);
  assign pulse_o = en_i & evt_i & (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (en_i && evt_i) cnt_q <= (cnt_q >= lim) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               inc_i,
  input  logic               clr_i,
  input  logic [CNT_W/8-1:0] wr_byte_i,
  input  logic [7:0]         wdata_i,
  input  logic               flag_wr_i,
  input  logic               flag_wdata_i,
  output logic [CNT_W-1:0]   count_o,
  output logic               flag_o
);
  localparam int NB = CNT_W / 8;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, ovf;

  assign ovf = inc_i & ~clr_i & ~(|wr_byte_i) & (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (|wr_byte_i) begin
      for (int b = 0; b < NB; b++)
        if (wr_byte_i[b]) cnt_d[b*8 +: 8] = wdata_i;
    end else if (inc_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= ovf | (flag_q & ~(flag_wr_i & ~flag_wdata_i));
    end
  end

  assign count_o = cnt_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/tmr16_periph.sv
module tmr16_periph
  import tmr16_pkg::*;
#(
  parameter int TICK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       ext_clk_i,
  input  logic       cmp_clr_i,
  output logic       irq_o
);
  localparam int CNT_W = 16;
  localparam int SEL_W = 2;

  ctrl_t            ctrl_q;
  logic             ie_q;
  logic [CNT_W-1:0] count_q;
  logic             ovf_flag_q;
  logic             src_evt, inc_w;
  logic             wr_ctrl, wr_lo, wr_hi, wr_irq;

  assign wr_ctrl = reg_we_i && (reg_addr_e'(reg_addr_i) == ADDR_CTRL);
  assign wr_lo   = reg_we_i && (reg_addr_e'(reg_addr_i) == ADDR_CNT_LO);
  assign wr_hi   = reg_we_i && (reg_addr_e'(reg_addr_i) == ADDR_CNT_HI);
  assign wr_irq  = reg_we_i && (reg_addr_e'(reg_addr_i) == ADDR_IRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ie_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q      <= ctrl_t'(reg_wdata_i);
        ctrl_q.rsvd <= 2'b00;
      end
      if (wr_irq) ie_q <= reg_wdata_i[1];
    end
  end

  tmr16_clk_src #(
    .TICK_DIV    (TICK_DIV),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_clk_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ext_i       (ext_clk_i),
    .src_ext_i   (ctrl_q.src_ext),
    .ext_async_i (ctrl_q.ext_async),
    .evt_o       (src_evt)
  );

  tmr16_prescaler #(
    .SEL_W (SEL_W)
  ) i_prescaler (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (src_evt),
    .en_i    (ctrl_q.run),
    .clr_i   (wr_lo | wr_hi),
    .sel_i   (ctrl_q.psc_sel),
    .pulse_o (inc_w)
  );

  tmr16_counter #(
    .CNT_W (CNT_W)
  ) i_counter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .inc_i        (inc_w),
    .clr_i        (cmp_clr_i),
    .wr_byte_i    ({wr_hi, wr_lo}),
    .wdata_i      (reg_wdata_i),
    .flag_wr_i    (wr_irq),
    .flag_wdata_i (reg_wdata_i[0]),
    .count_o      (count_q),
    .flag_o       (ovf_flag_q)
  );

  always_comb begin
    unique case (reg_addr_e'(reg_addr_i))
      ADDR_CTRL:   reg_rdata_o = ctrl_q;
      ADDR_CNT_LO: reg_rdata_o = count_q[7:0];
      ADDR_CNT_HI: reg_rdata_o = count_q[15:8];
      default:     reg_rdata_o = {6'b0, ie_q, ovf_flag_q};
    endcase
  end

  assign irq_o = ovf_flag_q & ie_q;
endmodule

// File: rtl/tmr16_periph_chk.sv
module tmr16_periph_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [1:0]  reg_addr_i,
  input logic        wdata0_i,
  input logic [1:0]  rdata_top_i,
  input logic        cmp_clr_i,
  input logic        irq_o,
  input logic [15:0] count_i,
  input logic        flag_i,
  input logic        run_i,
  input logic        inc_i
);
  logic cnt_wr;
  assign cnt_wr = reg_we_i && (reg_addr_i == 2'd1 || reg_addr_i == 2'd2);

  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd0) |-> (rdata_top_i == 2'b00));

  assert_cmp_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_clr_i |=> (count_i == 16'h0000));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cmp_clr_i && !cnt_wr) |=> $stable(count_i));

  assert_single_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_clr_i && !cnt_wr) |=>
      (count_i == $past(count_i) || count_i == $past(count_i) + 16'd1));

  assert_wrap_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && count_i == 16'hFFFF && !cmp_clr_i && !cnt_wr) |=> flag_i);

  assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !(reg_we_i && reg_addr_i == 2'd3 && !wdata0_i)) |=> flag_i);

  assert_irq_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_i);
endmodule

bind tmr16_periph tmr16_periph_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .wdata0_i    (reg_wdata_i[0]),
  .rdata_top_i (reg_rdata_o[7:6]),
  .cmp_clr_i   (cmp_clr_i),
  .irq_o       (irq_o),
  .count_i     (count_q),
  .flag_i      (ovf_flag_q),
  .run_i       (ctrl_q.run),
  .inc_i       (inc_w)
);

// File: tb/test_tmr16_periph.sv
module test_tmr16_periph;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       ext_clk_i = 1'b0;
  logic       cmp_clr_i = 1'b0;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  tmr16_periph i_tmr16_periph (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .ext_clk_i   (ext_clk_i),
    .cmp_clr_i   (cmp_clr_i),
    .irq_o       (irq_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic rd_cnt(output logic [15:0] c);
    logic [7:0] lo, hi;
    rd(2'd1, lo);
    rd(2'd2, hi);
    c = {hi, lo};
  endtask

  task automatic ext_pulse();
    @(negedge clk_i); ext_clk_i = 1'b1;
    repeat (2) @(negedge clk_i);
    ext_clk_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic load(input logic [7:0] ctrl, input logic [15:0] v);
    wr(2'd0, ctrl & 8'hFE);
    wr(2'd2, v[15:8]);
    wr(2'd1, v[7:0]);
    wr(2'd0, ctrl);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R1 reg after reset", {8'h0, d}, 16'h0000);
    end
    chk("R1 irq after reset", {15'h0, irq_o}, 16'h0000);
  endtask

  task automatic t_ctrl_rb();
    logic [7:0] d;
    wr(2'd0, 8'hFF);
    rd(2'd0, d);
    chk("R2 ctrl readback 0xFF", {8'h0, d}, 16'h003F);
    wr(2'd0, 8'h28);
    rd(2'd0, d);
    chk("R2 ctrl readback 0x28", {8'h0, d}, 16'h0028);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_internal();
    logic [15:0] c;
    for (int s = 0; s < 4; s++) begin
      load({2'b00, s[1:0], 4'b0001}, 16'h0000);
      repeat (64) @(negedge clk_i);
      rd_cnt(c);
      chk("R4 R6 internal prescale", c, 16'(16 >> s));
    end
  endtask

  task automatic t_internal_ignores_ext();
    logic [15:0] c;
    load(8'h05, 16'h0000);
    fork
      repeat (64) @(negedge clk_i);
      repeat (10) ext_pulse();
    join
    rd_cnt(c);
    chk("R8 internal ignores ext and sync bit", c, 16'd16);
  endtask

  task automatic t_hold();
    logic [15:0] c0, c1;
    wr(2'd0, 8'h00);
    rd_cnt(c0);
    repeat (40) @(negedge clk_i);
    ext_pulse();
    rd_cnt(c1);
    chk("R5 halted count holds", c1, c0);
  endtask

  task automatic t_latency(input logic async_sel);
    logic [15:0] c;
    load(async_sel ? 8'h07 : 8'h03, 16'h0000);
    repeat (3) @(negedge clk_i);
    ext_clk_i = 1'b1;
    @(negedge clk_i);
    rd_cnt(c);
    chk("R7 after edge k", c, 16'd0);
    @(negedge clk_i);
    rd_cnt(c);
    chk("R7 after edge k+1", c, async_sel ? 16'd1 : 16'd0);
    @(negedge clk_i);
    rd_cnt(c);
    chk("R7 after edge k+2", c, 16'd1);
    ext_clk_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_ext_prescale();
    logic [15:0] c;
    load(8'h27, 16'h0000);
    repeat (8) ext_pulse();
    rd_cnt(c);
    chk("R6 ext 1:4 eight edges", c, 16'd2);
  endtask

  task automatic t_wr_priority();
    logic [15:0] c;
    load(8'h07, 16'h0020);
    @(negedge clk_i); ext_clk_i = 1'b1;
    @(negedge clk_i); reg_we_i = 1'b1; reg_addr_i = 2'd1; reg_wdata_i = 8'h55;
    @(negedge clk_i); reg_we_i = 1'b0; ext_clk_i = 1'b0;
    rd_cnt(c);
    chk("R3 write beats increment", c, 16'h0055);
    repeat (4) @(negedge clk_i);
    rd_cnt(c);
    chk("R3 no late increment", c, 16'h0055);
    wr(2'd2, 8'hA1);
    rd_cnt(c);
    chk("R3 high byte write alone", c, 16'hA155);
  endtask

  task automatic t_psc_clear();
    logic [15:0] c;
    load(8'h17, 16'h0010);
    ext_pulse();
    rd_cnt(c);
    chk("R12 half step pending", c, 16'h0010);
    wr(2'd1, 8'h10);
    ext_pulse();
    rd_cnt(c);
    chk("R12 prescaler cleared by write", c, 16'h0010);
    ext_pulse();
    rd_cnt(c);
    chk("R12 step after two edges", c, 16'h0011);
  endtask

  task automatic t_overflow();
    logic [15:0] c;
    logic [7:0] d;
    load(8'h07, 16'hFFFF);
    ext_pulse();
    rd_cnt(c);
    chk("R9 wrap to zero", c, 16'h0000);
    rd(2'd3, d);
    chk("R9 flag set", {8'h0, d}, 16'h0001);
    chk("R10 irq low while disabled", {15'h0, irq_o}, 16'h0000);
    wr(2'd3, 8'h03);
    chk("R10 irq with enable", {15'h0, irq_o}, 16'h0001);
    rd(2'd3, d);
    chk("R10 write 1 keeps flag", {8'h0, d}, 16'h0003);
    wr(2'd3, 8'h02);
    rd(2'd3, d);
    chk("R10 write 0 clears flag", {8'h0, d}, 16'h0002);
    chk("R10 irq drops", {15'h0, irq_o}, 16'h0000);
  endtask

  task automatic t_ovf_race();
    logic [7:0] d;
    load(8'h07, 16'hFFFF);
    @(negedge clk_i); ext_clk_i = 1'b1;
    @(negedge clk_i); reg_we_i = 1'b1; reg_addr_i = 2'd3; reg_wdata_i = 8'h02;
    @(negedge clk_i); reg_we_i = 1'b0; ext_clk_i = 1'b0;
    rd(2'd3, d);
    chk("R10 set wins over clear", {8'h0, d}, 16'h0003);
    chk("R10 irq after race", {15'h0, irq_o}, 16'h0001);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_cmp_clear();
    logic [15:0] c;
    load(8'h00, 16'h1234);
    @(negedge clk_i);
    cmp_clr_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 2'd1; reg_wdata_i = 8'h77;
    @(negedge clk_i);
    cmp_clr_i = 1'b0; reg_we_i = 1'b0;
    rd_cnt(c);
    chk("R11 compare clear wins", c, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ctrl_rb();
    t_internal();
    t_internal_ignores_ext();
    t_hold();
    t_latency(1'b0);
    t_latency(1'b1);
    t_ext_prescale();
    t_wr_priority();
    t_psc_clear();
    t_overflow();
    t_ovf_race();
    t_cmp_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule